// File: doc/BRIEF.md
# Separable Fractional-Pel Motion Interpolator

This block produces the predicted samples of one prediction block for motion-compensated decoding with a single reference. Software or an upstream controller sets up the block: it selects luma or chroma, gives the fractional phase of the motion vector in x and in y, and gives the block width and height. A one-cycle start pulse then hands the block over. The reference window comes in one 8-bit pixel per handshake, in raster order. The window already includes the extra border columns and rows that the filter taps reach into.

Each row goes through a horizontal FIR as it arrives. The unshifted intermediate results are held in an on-chip buffer. Once the whole window has arrived, a vertical FIR runs on those buffered columns. The final samples stream out with valid/ready flow control. Luma uses an 8-tap filter at quarter-pel resolution and chroma uses a 4-tap filter at eighth-pel resolution. One datapath serves both, always horizontal first.

Top module: `interp_mc_top`

## Requirements
- R1: After reset, busy_o, ref_ready_o and out_valid_o are all low.
- R2: A start_i pulse while busy_o is low captures the configuration, and ref_ready_o is high in the following cycle. A start_i pulse while busy_o is high has no effect on the running block: the pixel count and the output values stay those of the first configuration.
- R3: The block accepts exactly (W+N-1)*(H+N-1) reference pixels in raster order, with N=8 for luma and N=4 for chroma. ref_ready_o drops right after the last pixel, and ref_ready_o and out_valid_o are never high together.
- R4: For luma (chroma_i=0), the phase is frac bits [1:0] and the taps are applied to window pixels offset 0..7:
  - phase 1: {-1,4,-10,58,17,-5,1,0}
  - phase 2: {-1,4,-11,40,40,-11,4,-1}
  - phase 3: {0,1,-5,17,58,-10,4,-1}
- R5: For chroma (chroma_i=1), the phase is frac bits [2:0] and the taps are applied to offsets 0..3:
  - phase 1: {-2,58,10,-2}
  - phase 2: {-4,54,16,-2}
  - phase 3: {-6,46,28,-4}
  - phase 4: {-4,36,36,-4}
  - phases 5 to 7 mirror phases 3 to 1.
- R6: Phase 0 in a direction acts as a single tap of 64 at offset N/2-1. A full-integer vector therefore returns the reference pixel at window position (y+N/2-1, x+N/2-1) unchanged.
- R7: The horizontal result is kept unshifted as a signed 16-bit value. The vertical sum is shifted right arithmetically by 6, then 32 is added and the value is shifted right by 6 again. The result is clipped to 0..255.
- R8: W*H samples leave in raster order. While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o hold.
- R9: Width and height are set independently, each from 1 to MAX_W and MAX_H, so non-square blocks work.
- R10: busy_o returns low in the cycle after the last output sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, captures the configuration when idle |
| chroma_i | input | 1 | 1 selects the 4-tap chroma filter, 0 selects the 8-tap luma filter |
| frac_x_i | input | 3 | Horizontal fractional phase |
| frac_y_i | input | 3 | Vertical fractional phase |
| width_i | input | $clog2(MAX_W+1) | Block width in samples |
| height_i | input | $clog2(MAX_H+1) | Block height in samples |
| busy_o | output | 1 | A block is in progress |
| ref_valid_i | input | 1 | Reference pixel valid |
| ref_data_i | input | 8 | Reference pixel |
| ref_ready_o | output | 1 | Reference pixel accepted this cycle when valid |
| out_valid_o | output | 1 | Predicted sample valid |
| out_data_o | output | 8 | Predicted sample |
| out_ready_i | input | 1 | Downstream accepts the sample |

## Verification
The assertions assume several things about the inputs. Width and height are never zero and never exceed the limits. Configuration is only meaningful when start_i arrives while the block is idle. Downstream may stall for any number of cycles. The bench keeps within these limits in every block it runs: it drives sizes of 1 to 16 only, and it fires its one extra start pulse in the middle of a load, so that pulse must be ignored. The bench also stalls randomly on both the reference input and the output, so the hold property is exercised under backpressure.

// File: rtl/interp_pkg.sv
package interp_pkg;
  parameter int PIX_W  = 8;
  parameter int LTAPS  = 8;
  parameter int CTAPS  = 4;
  parameter int HACC_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_OUT} state_e;

  function automatic int luma_q(input int k);
    case (k)
      0: return -1;  1: return 4;  2: return -10; 3: return 58;
      4: return 17;  5: return -5; 6: return 1;   default: return 0;
    endcase
  endfunction

  function automatic int luma_h(input int k);
    case (k)
      0, 7: return -1;
      1, 6: return 4;
      2, 5: return -11;
      default: return 40;
    endcase
  endfunction

  function automatic int chroma_base(input int ph, input int k);
    case (ph)
      1: case (k) 0: return -2; 1: return 58; 2: return 10; default: return -2; endcase
      2: case (k) 0: return -4; 1: return 54; 2: return 16; default: return -2; endcase
      3: case (k) 0: return -6; 1: return 46; 2: return 28; default: return -4; endcase
      4: case (k) 0: return -4; 1: return 36; 2: return 36; default: return -4; endcase
      default: return (k == 1) ? 64 : 0;
    endcase
  endfunction

  // coefficient k of the selected filter; zero-phase acts as a 64 at the centre tap
  function automatic int tap_coef(input logic chroma, input logic [2:0] ph, input int k);
    if (!chroma) begin
      case (ph[1:0])
        2'd0: return (k == LTAPS/2-1) ? 64 : 0;
        2'd1: return luma_q(k);
        2'd2: return luma_h(k);
        default: return luma_q(LTAPS-1-k);
      endcase
    end
    if (k >= CTAPS) return 0;
    if (ph > 3'd4) return chroma_base(8 - int'(ph), CTAPS-1-k);
    return chroma_base(int'(ph), k);
  endfunction
endpackage

// File: rtl/interp_hfilt.sv
module interp_hfilt
  import interp_pkg::*;
(
  input  logic                     chroma_i,
  input  logic [2:0]               phase_i,
  input  logic [PIX_W-1:0]         win_i [LTAPS],
  output logic signed [HACC_W-1:0] h_o
);
  int acc;
  always_comb begin
    acc = 0;
    for (int k = 0; k < LTAPS; k++) begin
      if (!chroma_i)
        acc += int'(win_i[k]) * tap_coef(chroma_i, phase_i, k);
      else if (k < CTAPS)
        acc += int'(win_i[k+LTAPS-CTAPS]) * tap_coef(chroma_i, phase_i, k);
    end
    h_o = HACC_W'(acc);
  end
endmodule

// File: rtl/interp_vfilt.sv
module interp_vfilt
  import interp_pkg::*;
(
  input  logic                     chroma_i,
  input  logic [2:0]               phase_i,
  input  logic signed [HACC_W-1:0] col_i [LTAPS],
  output logic [PIX_W-1:0]         pix_o
);
  int acc, v, r;
  always_comb begin
    acc = 0;
    for (int k = 0; k < LTAPS; k++)
      if (!chroma_i || k < CTAPS)
        acc += int'(col_i[k]) * tap_coef(chroma_i, phase_i, k);
    v = acc >>> 6;
    r = (v + 32) >>> 6;
    if (r < 0)                  pix_o = '0;
    else if (r > (1<<PIX_W)-1)  pix_o = '1;
    else                        pix_o = PIX_W'(r);
  end
endmodule

// File: rtl/interp_mc_top.sv
module interp_mc_top
  import interp_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int MAX_H = 16,
  localparam int DW = $clog2(MAX_W+1),
  localparam int HW = $clog2(MAX_H+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             chroma_i,
  input  logic [2:0]       frac_x_i,
  input  logic [2:0]       frac_y_i,
  input  logic [DW-1:0]    width_i,
  input  logic [HW-1:0]    height_i,
  output logic             busy_o,
  input  logic             ref_valid_i,
  input  logic [PIX_W-1:0] ref_data_i,
  output logic             ref_ready_o,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_data_o,
  input  logic             out_ready_i
);
  localparam int BUF_ROWS = MAX_H + LTAPS - 1;
  localparam int DEPTH    = BUF_ROWS * MAX_W;
  localparam int BW       = $clog2(DEPTH);
  localparam int CW       = $clog2(MAX_W + LTAPS);
  localparam int RW       = $clog2(BUF_ROWS + 1);

  state_e              state_q;
  logic                chroma_q;
  logic [2:0]          fx_q, fy_q;
  logic [DW-1:0]       w_q, ox_q;
  logic [HW-1:0]       h_q, oy_q;
  logic [CW-1:0]       cin_q;
  logic [RW-1:0]       rin_q;
  logic [PIX_W-1:0]    sr_q [LTAPS];
  logic [PIX_W-1:0]    sr_d [LTAPS];
  logic signed [HACC_W-1:0] hbuf [DEPTH];
  logic signed [HACC_W-1:0] h_res;
  logic signed [HACC_W-1:0] col [LTAPS];

  logic [3:0]    ntaps;
  logic [CW-1:0] col_last;
  logic [RW-1:0] row_last;
  logic          take, give, h_ok;
  logic [BW-1:0] wr_addr;

  assign ntaps    = chroma_q ? 4'(CTAPS) : 4'(LTAPS);
  assign col_last = CW'(w_q) + CW'(ntaps) - CW'(2);
  assign row_last = RW'(h_q) + RW'(ntaps) - RW'(2);
  assign take     = (state_q == ST_LOAD) && ref_valid_i;
  assign give     = (state_q == ST_OUT) && out_ready_i;
  assign h_ok     = cin_q >= CW'(ntaps - 4'd1);
  assign wr_addr  = BW'(rin_q) * BW'(MAX_W) + BW'(cin_q - CW'(ntaps - 4'd1));

  assign busy_o      = state_q != ST_IDLE;
  assign ref_ready_o = state_q == ST_LOAD;
  assign out_valid_o = state_q == ST_OUT;

  // window of the newest LTAPS pixels of the row, oldest first
  always_comb begin
    for (int k = 0; k < LTAPS-1; k++) sr_d[k] = sr_q[k+1];
    sr_d[LTAPS-1] = ref_data_i;
  end

  interp_hfilt u_hfilt (
    .chroma_i(chroma_q), .phase_i(fx_q), .win_i(sr_d), .h_o(h_res)
  );

  for (genvar k = 0; k < LTAPS; k++) begin : g_col
    assign col[k] = hbuf[BW'((int'(oy_q) + k) * MAX_W + int'(ox_q))];
  end

  interp_vfilt u_vfilt (
    .chroma_i(chroma_q), .phase_i(fy_q), .col_i(col), .pix_o(out_data_o)
  );

  always_ff @(posedge clk_i) begin
    if (take && h_ok) hbuf[wr_addr] <= h_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      chroma_q <= 1'b0;
      fx_q     <= '0;
      fy_q     <= '0;
      w_q      <= '0;
      h_q      <= '0;
      cin_q    <= '0;
      rin_q    <= '0;
      ox_q     <= '0;
      oy_q     <= '0;
      for (int k = 0; k < LTAPS; k++) sr_q[k] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          chroma_q <= chroma_i;
          fx_q     <= frac_x_i;
          fy_q     <= frac_y_i;
          w_q      <= width_i;
          h_q      <= height_i;
          cin_q    <= '0;
          rin_q    <= '0;
          state_q  <= ST_LOAD;
        end
        ST_LOAD: if (take) begin
          sr_q <= sr_d;
          if (cin_q == col_last) begin
            cin_q <= '0;
            rin_q <= rin_q + RW'(1);
            if (rin_q == row_last) begin
              ox_q    <= '0;
              oy_q    <= '0;
              state_q <= ST_OUT;
            end
          end else begin
            cin_q <= cin_q + CW'(1);
          end
        end
        ST_OUT: if (give) begin
          if (ox_q == w_q - DW'(1)) begin
            ox_q <= '0;
            if (oy_q == h_q - HW'(1)) state_q <= ST_IDLE;
            else                      oy_q <= oy_q + HW'(1);
          end else begin
            ox_q <= ox_q + DW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/interp_mc_chk.sv
module interp_mc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       ref_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o
);
  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R3
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_ready_o && out_valid_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ref_ready_o && !out_valid_o);

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> ref_ready_o);
endmodule

bind interp_mc_top interp_mc_chk u_chk (.*);

// File: tb/tb_interp_mc_top.sv
module tb_interp_mc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, chroma = 1'b0;
  logic [2:0] fx = '0, fy = '0;
  logic [4:0] w_in = '0, h_in = '0;
  logic       busy, ref_valid = 1'b0, ref_ready, out_valid, out_ready = 1'b0;
  logic [7:0] ref_data = '0, out_data;

  int checks = 0, errors = 0;
  int win [23][23];
  int expq [256];

  localparam int LT [4][8] = '{
    '{0, 0, 0, 64, 0, 0, 0, 0},
    '{-1, 4, -10, 58, 17, -5, 1, 0},
    '{-1, 4, -11, 40, 40, -11, 4, -1},
    '{0, 1, -5, 17, 58, -10, 4, -1}};
  localparam int CT [8][4] = '{
    '{0, 64, 0, 0}, '{-2, 58, 10, -2}, '{-4, 54, 16, -2}, '{-6, 46, 28, -4},
    '{-4, 36, 36, -4}, '{-4, 28, 46, -6}, '{-2, 16, 54, -4}, '{-2, 10, 58, -2}};

  always #4 clk = ~clk;

  interp_mc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chroma_i(chroma),
    .frac_x_i(fx), .frac_y_i(fy), .width_i(w_in), .height_i(h_in),
    .busy_o(busy), .ref_valid_i(ref_valid), .ref_data_i(ref_data),
    .ref_ready_o(ref_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int coef(input bit c, input int ph, input int k);
    if (c) return (k < 4) ? CT[ph][k] : 0;
    return LT[ph % 4][k];
  endfunction

  // R4 R5 R6 R7 reference model
  task automatic model(input bit c, input int px, input int py, input int w, input int h);
    int n = c ? 4 : 8;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        int v = 0;
        for (int ky = 0; ky < n; ky++) begin
          int hs = 0;
          for (int kx = 0; kx < n; kx++) hs += coef(c, px, kx) * win[y+ky][x+kx];
          v += coef(c, py, ky) * hs;
        end
        v = v >>> 6;
        v = (v + 32) >>> 6;
        expq[y*w+x] = (v < 0) ? 0 : (v > 255) ? 255 : v;
      end
  endtask

  task automatic run_block(input bit c, input int px, input int py, input int w, input int h,
                           input int pat, input bit stall, input bit mid, input string tag);
    int n = c ? 4 : 8;
    int cols = w + n - 1, rows = h + n - 1;
    int idx = 0, k = 0, guard = 0;
    bit held = 0;
    int hv = 0;
    for (int r = 0; r < rows; r++)
      for (int q = 0; q < cols; q++)
        case (pat)
          1: win[r][q] = 255;
          2: win[r][q] = ((r + q) % 2) ? 255 : 0;
          3: win[r][q] = (r * 16 + q * 3) % 256;
          default: win[r][q] = int'($urandom % 256);
        endcase
    model(c, px, py, w, h);
    @(negedge clk);
    chroma = c; fx = 3'(px); fy = 3'(py); w_in = 5'(w); h_in = 5'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ref_ready === 1'b1, {tag, " R2 ready after start"}, int'(ref_ready), 1);
    while (idx < cols * rows && guard < 20000) begin
      bit rdy;
      ref_valid = !(stall && ($urandom % 4 == 0));
      ref_data = 8'(win[idx / cols][idx % cols]);
      if (mid && idx == 5) begin start = 1'b1; chroma = ~c; w_in = 5'd1; h_in = 5'd1; end
      rdy = ref_ready;
      @(negedge clk);
      start = 1'b0;
      if (rdy && ref_valid) idx++;
      guard++;
    end
    ref_valid = 1'b0;
    chk(ref_ready === 1'b0 && out_valid === 1'b1, {tag, " R3 load ends after window"},
        int'(ref_ready), 0);
    guard = 0;
    while (k < w * h && guard < 20000) begin
      out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      if (held) begin
        chk(out_valid === 1'b1 && int'(out_data) == hv, {tag, " R8 hold under stall"},
            int'(out_data), hv);
        held = 0;
      end
      if (out_valid && out_ready) begin
        chk(int'(out_data) == expq[k], $sformatf("%s R7 sample %0d", tag, k),
            int'(out_data), expq[k]);
        k++;
      end else if (out_valid) begin
        held = 1; hv = int'(out_data);
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1'b0;
    chk(k == w * h, {tag, " R8 sample count"}, k, w * h);
    chk(busy === 1'b0, {tag, " R10 idle after last"}, int'(busy), 0);
  endtask

  task automatic test_reset();
    #1;
    chk(busy === 1'b0 && ref_ready === 1'b0 && out_valid === 1'b0, "R1 reset state",
        int'({busy, ref_ready, out_valid}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 idle after reset", int'(busy), 0);
  endtask

  task automatic test_luma_phases();
    for (int px = 0; px < 4; px++)
      for (int py = 0; py < 4; py++)
        run_block(1'b0, px, py, 4, 4, 0, 1'b0, 1'b0, $sformatf("R4 luma %0d/%0d", px, py));
  endtask

  task automatic test_chroma_phases();
    for (int px = 0; px < 8; px++)
      for (int py = 0; py < 8; py++)
        run_block(1'b1, px, py, 2, 2, 0, 1'b0, 1'b0, $sformatf("R5 chroma %0d/%0d", px, py));
  endtask

  task automatic test_integer();
    run_block(1'b0, 0, 0, 8, 4, 3, 1'b0, 1'b0, "R6 luma integer");
    for (int i = 0; i < 32; i++)
      chk(expq[i] == win[i/8 + 3][i%8 + 3], "R6 luma passthrough model", expq[i], win[i/8+3][i%8+3]);
    run_block(1'b1, 0, 0, 4, 4, 0, 1'b0, 1'b0, "R6 chroma integer");
  endtask

  task automatic test_clip();
    run_block(1'b0, 2, 2, 4, 4, 2, 1'b0, 1'b0, "R7 clip checker");
    run_block(1'b0, 1, 3, 4, 4, 1, 1'b0, 1'b0, "R7 flat white");
    run_block(1'b1, 4, 4, 4, 4, 2, 1'b0, 1'b0, "R7 chroma checker");
  endtask

  task automatic test_shapes();
    run_block(1'b0, 1, 2, 16, 4, 0, 1'b0, 1'b0, "R9 luma 16x4");
    run_block(1'b1, 3, 6, 4, 16, 0, 1'b0, 1'b0, "R9 chroma 4x16");
    run_block(1'b0, 3, 1, 1, 1, 0, 1'b0, 1'b0, "R9 luma 1x1");
    run_block(1'b0, 2, 1, 12, 16, 0, 1'b0, 1'b0, "R9 luma 12x16");
  endtask

  task automatic test_stall();
    run_block(1'b0, 3, 2, 8, 8, 0, 1'b1, 1'b0, "R8 luma backpressure");
    run_block(1'b1, 7, 5, 8, 4, 0, 1'b1, 1'b0, "R8 chroma backpressure");
  endtask

  task automatic test_busy_start();
    run_block(1'b0, 2, 3, 4, 4, 0, 1'b0, 1'b1, "R2 start while busy");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_luma_phases();
    test_chroma_phases();
    test_integer();
    test_clip();
    test_shapes();
    test_stall();
    test_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule